// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block watches the running calendar time (seconds, minutes, hours, day of month and month, all held as two-digit BCD bytes) and compares it with a programmed alarm time. Each of the five fields has its own skip bit. A set skip bit takes that field out of the comparison, so the same hardware can raise an alarm every second, every minute, every hour, every day or every month.

The comparison is taken only on the cycle that carries the one-second tick from the timekeeper. When the alarm is enabled and every field that is not skipped is equal, a sticky alarm flag is set. An active-low request output follows the flag. The flag stays set until the host writes a 0 into its bit of the control/status byte. Turning the enable off stops any further setting, but it leaves a flag that is already raised untouched.

Top module: `alarm_match_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `alarm_flag` is 0 and `alarm_req_n` is 1.
- R2: With all five skip bits at 1 and `alarm_en` high, the flag is 1 in the cycle after a tick.
- R3: A field whose skip bit is 0 must equal its alarm byte. A mismatch in any such field, the month included, keeps the flag from being set.
- R4: A field whose skip bit is 1 does not affect the result, whatever its value. Skip bit order is 0=seconds, 1=minutes, 2=hours, 3=date, 4=month.
- R5: While `alarm_en` is 0, a matching tick does not set the flag.
- R6: The flag holds until a host write with bit 6 of `csr_wdata` at 0 clears it in the next cycle. A write with bit 6 at 1 leaves the flag as it is.
- R7: Dropping `alarm_en` while the flag is set does not clear it.
- R8: `alarm_req_n` is always the inverse of `alarm_flag` (active low).
- R9: A match is evaluated only in a cycle where `sec_tick` is 1. A match without a tick does not set the flag.
- R10: If a clearing write and a setting match fall in the same cycle, the flag is 1 afterwards.
- R11: Fields are compared as raw BCD bytes. For example, alarm byte 0x59 does not match the binary value 59 (0x3B).
- R12: With only seconds unmasked, the flag is set once per minute. With seconds and minutes unmasked, it is set once per hour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per second from the timekeeper |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| cur_month | input | 8 | Current month, BCD |
| alm_sec | input | 8 | Alarm seconds, BCD |
| alm_min | input | 8 | Alarm minutes, BCD |
| alm_hour | input | 8 | Alarm hours, BCD |
| alm_date | input | 8 | Alarm day of month, BCD |
| alm_month | input | 8 | Alarm month, BCD |
| alm_skip | input | 5 | Per-field skip bits (1 = field not compared) |
| alarm_en | input | 1 | Alarm enable |
| csr_wr | input | 1 | Write strobe for the control/status byte |
| csr_wdata | input | 8 | Write data; bit 6 written as 0 clears the flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_req_n | output | 1 | Alarm request, active low |

## Verification
The assertions check the flag's cycle-to-cycle rules on every clock: setting after an enabled matching tick, holding without a clearing write, clearing on such a write, no change without a tick or without the enable, and the inverted request output. Whether the field comparison itself is right cannot be judged from these rules. That includes skip-bit decoding, exact BCD equality, the month field and the resulting alarm rates. The bench shows these with a behavioural model and with time sweeps that count how often the flag is set over simulated minutes and hours.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int NUM_FIELDS = 5;
    localparam int FIELD_W    = 8;
    localparam int CSR_W      = 8;
    localparam int FLAG_BIT   = 6;
    localparam int STAMP_W    = NUM_FIELDS * FIELD_W;

    // Position of each field inside a stamp and inside the skip vector
    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4
    } field_e;

    typedef logic [FIELD_W-1:0] bcd_t;

    // Seconds occupy the least significant byte
    typedef struct packed {
        bcd_t month;
        bcd_t date;
        bcd_t hour;
        bcd_t min;
        bcd_t sec;
    } stamp_t;

    function automatic bcd_t stamp_field(input stamp_t s, input field_e f);
        logic [STAMP_W-1:0] flat;
        flat = s;
        return flat[int'(f)*FIELD_W +: FIELD_W];
    endfunction

    function automatic logic is_clear_write(input logic wr, input logic [CSR_W-1:0] data);
        return wr && !data[FLAG_BIT];
    endfunction

endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] tgt_i,
    input  logic         skip_i,
    output logic         hit_o
);
    // Raw byte equality: BCD digits are compared as stored
    always_comb begin
        hit_o = skip_i || (cur_i == tgt_i);
    end
endmodule

// File: rtl/alarm_flag_reg.sv
module alarm_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic en_i,
    input  logic hit_i,
    input  logic clr_i,
    output logic flag_o
);
    logic set_now;

    always_comb begin
        set_now = tick_i && en_i && hit_i;
    end

    // A set in the same cycle as a clear takes priority
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_now) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sec_tick,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_date,
    input  logic [FIELD_W-1:0] cur_month,
    input  logic [FIELD_W-1:0] alm_sec,
    input  logic [FIELD_W-1:0] alm_min,
    input  logic [FIELD_W-1:0] alm_hour,
    input  logic [FIELD_W-1:0] alm_date,
    input  logic [FIELD_W-1:0] alm_month,
    input  logic [NUM_FIELDS-1:0] alm_skip,
    input  logic               alarm_en,
    input  logic               csr_wr,
    input  logic [CSR_W-1:0]   csr_wdata,
    output logic               alarm_flag,
    output logic               alarm_req_n
);
    stamp_t                now_s;
    stamp_t                tgt_s;
    logic [NUM_FIELDS-1:0] hits;
    logic                  all_hit;
    logic                  clr_req;
    logic                  unused_csr;

    always_comb begin
        now_s = '{month: cur_month, date: cur_date, hour: cur_hour,
                  min: cur_min, sec: cur_sec};
        tgt_s = '{month: alm_month, date: alm_date, hour: alm_hour,
                  min: alm_min, sec: alm_sec};
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        alarm_field_cmp #(.W(FIELD_W)) u_cmp (
            .cur_i  (stamp_field(now_s, field_e'(i))),
            .tgt_i  (stamp_field(tgt_s, field_e'(i))),
            .skip_i (alm_skip[i]),
            .hit_o  (hits[i])
        );
    end

    always_comb begin
        all_hit    = &hits;
        clr_req    = is_clear_write(csr_wr, csr_wdata);
        unused_csr = ^csr_wdata;
    end

    alarm_flag_reg u_flag (
        .clk    (clk),
        .rst    (rst),
        .tick_i (sec_tick),
        .en_i   (alarm_en),
        .hit_i  (all_hit),
        .clr_i  (clr_req),
        .flag_o (alarm_flag)
    );

    always_comb begin
        alarm_req_n = !alarm_flag;
    end
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
    import alarm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sec_tick,
    input logic             alarm_en,
    input logic             csr_wr,
    input logic [CSR_W-1:0] csr_wdata,
    input logic             all_hit,
    input logic             alarm_flag,
    input logic             alarm_req_n
);
    logic wr_clears;
    logic unused_chk;

    always_comb begin
        wr_clears  = csr_wr && (csr_wdata[FLAG_BIT] == 1'b0);
        unused_chk = ^csr_wdata;
    end

    // R1: reset leaves the flag low
    a_r1_reset_low: assert property (@(posedge clk) rst |=> !alarm_flag);

    // R2, R10: an enabled matching tick sets the flag, even against a clear
    a_r2_set_on_match: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && alarm_en && all_hit) |=> alarm_flag);

    // R5: disabled alarm never raises a low flag
    a_r5_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
        (!alarm_en && !alarm_flag) |=> !alarm_flag);

    // R9: no tick, no rise
    a_r9_no_tick_no_set: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !alarm_flag) |=> !alarm_flag);

    // R6, R7: flag holds unless a clearing write arrives
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !wr_clears) |=> alarm_flag);

    // R6: clearing write with no competing match drops the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && wr_clears && !(sec_tick && alarm_en && all_hit)) |=> !alarm_flag);

    // R8: request pin is the inverted flag
    always @(posedge clk) begin
        if (!rst) begin
            a_r8_req_polarity: assert (alarm_req_n == !alarm_flag);
        end
    end
endmodule

bind alarm_match_unit alarm_match_chk u_chk (.*);

// File: tb/sim_alarm_match_unit.sv
`timescale 1ns/1ps
module sim_alarm_match_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
    logic [7:0] cur_date = 8'h01, cur_month = 8'h01;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
    logic [7:0] alm_date = 8'h01, alm_month = 8'h01;
    logic [4:0] alm_skip = 5'b11111;
    logic       alarm_en = 1'b0;
    logic       csr_wr = 1'b0;
    logic [7:0] csr_wdata = 8'h00;
    logic       alarm_flag, alarm_req_n;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    model_flag = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    alarm_match_unit u0 (.*);

    function automatic bit fields_match();
        bit ok = 1'b1;
        if (!alm_skip[0] && cur_sec   != alm_sec)   ok = 1'b0;
        if (!alm_skip[1] && cur_min   != alm_min)   ok = 1'b0;
        if (!alm_skip[2] && cur_hour  != alm_hour)  ok = 1'b0;
        if (!alm_skip[3] && cur_date  != alm_date)  ok = 1'b0;
        if (!alm_skip[4] && cur_month != alm_month) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    // Behavioural reference: updated at each rising edge
    always @(posedge clk) begin
        if (rst) model_flag <= 1'b0;
        else if (sec_tick && alarm_en && fields_match()) model_flag <= 1'b1;
        else if (csr_wr && !csr_wdata[6]) model_flag <= 1'b0;
    end

    task automatic check(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, alarm_flag, model_flag);
            check("R8", alarm_req_n, !model_flag);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick_once();
        sec_tick = 1'b1;
        cyc(1);
        sec_tick = 1'b0;
    endtask

    task automatic write_csr(input logic [7:0] d);
        csr_wr = 1'b1; csr_wdata = d;
        cyc(1);
        csr_wr = 1'b0; csr_wdata = 8'h00;
    endtask

    initial begin
        #(5.0 * 150000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int count;
        cyc(2);
        check("R1", alarm_flag, 1'b0);
        check("R1", alarm_req_n, 1'b1);
        rst = 1'b0;
        cyc(1);
        check("R1", alarm_flag, 1'b0);

        // R9: matching fields, enabled, but no tick
        cur_req = "R9"; alarm_en = 1'b1; alm_skip = 5'b11111;
        cyc(4);
        check("R9", alarm_flag, 1'b0);

        // R2: every field skipped, tick sets flag
        cur_req = "R2";
        tick_once();
        check("R2", alarm_flag, 1'b1);
        check("R8", alarm_req_n, 1'b0);

        // R6: write with bit 6 high keeps, bit 6 low clears
        cur_req = "R6";
        write_csr(8'h40);
        check("R6", alarm_flag, 1'b1);
        cyc(3);
        check("R6", alarm_flag, 1'b1);
        write_csr(8'hBF);
        check("R6", alarm_flag, 1'b0);

        // R5: disabled alarm ignores matching tick
        cur_req = "R5"; alarm_en = 1'b0;
        tick_once();
        check("R5", alarm_flag, 1'b0);

        // R7: set, then disable; flag stays
        cur_req = "R7"; alarm_en = 1'b1;
        tick_once();
        alarm_en = 1'b0;
        cyc(4);
        check("R7", alarm_flag, 1'b1);
        write_csr(8'h00);
        alarm_en = 1'b1;

        // R3: unmasked seconds must match
        cur_req = "R3"; alm_skip = 5'b11110; alm_sec = 8'h15; cur_sec = 8'h14;
        tick_once();
        check("R3", alarm_flag, 1'b0);
        cur_sec = 8'h15;
        tick_once();
        check("R3", alarm_flag, 1'b1);
        write_csr(8'h00);
        // R3: month mismatch alone blocks
        alm_skip = 5'b00000; cur_sec = 8'h15; alm_min = cur_min; alm_hour = cur_hour;
        alm_date = cur_date; alm_month = 8'h12; cur_month = 8'h11;
        tick_once();
        check("R3", alarm_flag, 1'b0);
        cur_month = 8'h12;
        tick_once();
        check("R3", alarm_flag, 1'b1);
        write_csr(8'h00);

        // R4: skipped fields may differ
        cur_req = "R4"; alm_skip = 5'b10101; cur_sec = 8'h33; cur_hour = 8'h07;
        cur_month = 8'h05;
        tick_once();
        check("R4", alarm_flag, 1'b1);
        write_csr(8'h00);

        // R11: BCD byte vs binary value
        cur_req = "R11"; alm_skip = 5'b11110; alm_sec = 8'h59; cur_sec = 8'd59;
        tick_once();
        check("R11", alarm_flag, 1'b0);
        cur_sec = 8'h59;
        tick_once();
        check("R11", alarm_flag, 1'b1);

        // R10: clear and match in the same cycle
        cur_req = "R10";
        sec_tick = 1'b1; csr_wr = 1'b1; csr_wdata = 8'h00;
        cyc(1);
        sec_tick = 1'b0; csr_wr = 1'b0;
        check("R10", alarm_flag, 1'b1);
        write_csr(8'h00);
        check("R6", alarm_flag, 1'b0);

        // R12: once per minute over 150 seconds
        cur_req = "R12"; alm_skip = 5'b11110; alm_sec = 8'h30;
        cur_date = 8'h01; cur_month = 8'h01; count = 0;
        for (int t = 0; t < 150; t++) begin
            cur_sec = to_bcd(t % 60); cur_min = to_bcd((t / 60) % 60);
            cur_hour = to_bcd(t / 3600);
            tick_once();
            if (alarm_flag) begin count++; write_csr(8'h00); end
        end
        n_checks++;
        if (count != 2) begin
            n_errors++;
            $display("FAIL R12: got %0d minute alarms expected 2", count);
        end

        // R12: once per hour over two hours
        alm_skip = 5'b11100; alm_sec = 8'h00; alm_min = 8'h01; count = 0;
        for (int t = 0; t < 7200; t++) begin
            cur_sec = to_bcd(t % 60); cur_min = to_bcd((t / 60) % 60);
            cur_hour = to_bcd(t / 3600);
            tick_once();
            if (alarm_flag) begin count++; write_csr(8'h00); end
        end
        n_checks++;
        if (count != 2) begin
            n_errors++;
            $display("FAIL R12: got %0d hour alarms expected 2", count);
        end

        cyc(2);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule